// File: doc/BRIEF.md
# NAND Hamming ECC Generator

This block produces the 3-byte single-error-correcting Hamming code that protects one 256-byte data block of a NAND page. Data bytes stream in one per clock under `valid_i`. The first byte of a block is flagged with `start_i`. While the block streams in, the block keeps running column-parity and line-parity accumulators. One cycle after the last byte it raises `done_o` and presents the three code bytes. They stay there until the next block starts.

Column parity is a 6-bit XOR of per-byte column groups. Line parity is kept as two 8-bit registers. For every byte of odd parity, one register collects the byte's index and the other collects the complement of that index. The output stage interleaves and inverts the line parities. It pads the column byte with two ones. A parameter chooses which of the two line-parity words is emitted first.

Top module: `nand_hecc_gen`

## Requirements
- R1: After reset, `done_o` is 0 and `ecc0_o`, `ecc1_o` and `ecc2_o` all read 0xFF.
- R2: A byte d contributes column parity bits c0..c5, where c0 = XOR of d bits {0,2,4,6}, c1 = XOR of bits {1,3,5,7}, c2 = XOR of bits {0,1,4,5}, c3 = XOR of bits {2,3,6,7}, c4 = XOR of bits {0,1,2,3} and c5 = XOR of bits {4,5,6,7}. The contributions of all bytes of the block are XOR-accumulated. For example, a block holding 0x01 at index 0 followed by zeros gives column parity 0x15.
- R3: For every byte whose eight bits XOR to 1, line register A is XORed with the byte's index (0..255) and line register B with the bitwise complement of that index.
- R4: With `ALT_ORDER`=0, `ecc0_o` = ~{A7,B7,A6,B6,A5,B5,A4,B4} and `ecc1_o` = ~{A3,B3,A2,B2,A1,B1,A0,B0}. The listed bits run MSB first.
- R5: With `ALT_ORDER`=1, the two line-parity bytes are swapped: `ecc0_o` carries the low-half word and `ecc1_o` carries the high-half word.
- R6: `ecc2_o` = {~c5,~c4,~c3,~c2,~c1,~c0,1,1}, built from the accumulated column parity.
- R7: `start_i` takes effect only together with `valid_i`. That byte becomes index 0 of a new block, and all earlier accumulation is discarded.
- R8: `done_o` rises in the cycle after the edge that accepts the 256th byte of a block, and never earlier.
- R9: While `done_o` is high, the three ECC outputs hold. Valid bytes without `start_i` are ignored until the next start.
- R10: Cycles with `valid_i` low neither advance the byte index nor change any accumulator.
- R11: A start during an unfinished block restarts the count, so the code covers only the 256 bytes that follow the latest start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks the first byte of a block (qualified by valid_i) |
| valid_i | input | 1 | Data byte present |
| data_i | input | 8 | Data byte |
| done_o | output | 1 | Code bytes valid for the finished block |
| ecc0_o | output | 8 | ECC byte 0 |
| ecc1_o | output | 8 | ECC byte 1 |
| ecc2_o | output | 8 | ECC byte 2 (column parity) |

## Verification
Each accepted byte changes the accumulators at the rising edge that takes it. The code bytes follow from those registers with no further register, so `done_o` and all three ECC bytes are due exactly one edge after the 256th byte. After that they must hold until a start byte is accepted. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. It then compares `done_o` at every falling edge, and compares the ECC bytes of both an `ALT_ORDER`=0 instance and an `ALT_ORDER`=1 instance whenever the model says a block is complete. Directed checks cover a single-byte pattern with known code bytes, an all-0xFF block, bit-flipped blocks, gaps in `valid_i`, bytes after completion and restarts.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;
  localparam int unsigned IDX_W  = 8;   // 256-byte block
  localparam int unsigned COL_W  = 6;
  localparam int unsigned BYTE_W = 8;

  // bit j of a byte belongs to column group k when bit (k/2) of j equals k%2
  function automatic logic [BYTE_W-1:0] col_mask(input int unsigned k);
    logic [BYTE_W-1:0] m;
    for (int unsigned j = 0; j < BYTE_W; j++)
      m[j] = (((j >> (k / 2)) & 1) == (k % 2));
    return m;
  endfunction
endpackage

// File: rtl/hecc_byte_par.sv
module hecc_byte_par
  import nand_hecc_pkg::*;
(
  input  logic [BYTE_W-1:0] d_i,
  output logic [COL_W-1:0]  col_o,
  output logic              odd_o
);
  for (genvar k = 0; k < COL_W; k++) begin : g_col
    localparam logic [BYTE_W-1:0] MASK = col_mask(k);
    assign col_o[k] = ^(d_i & MASK);
  end
  assign odd_o = ^d_i;
endmodule

// File: rtl/hecc_accum.sv
module hecc_accum
  import nand_hecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              odd_i,
  output logic [COL_W-1:0]  col_o,
  output logic [IDX_W-1:0]  lpa_o,
  output logic [IDX_W-1:0]  lpb_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  logic [COL_W-1:0] col_q;
  logic [IDX_W-1:0] lpa_q, lpb_q, cnt_q;
  logic             active_q, done_q;

  logic             sop, take;
  logic [COL_W-1:0] col_base;
  logic [IDX_W-1:0] lpa_base, lpb_base, idx;

  assign sop      = valid_i & start_i;
  assign take     = valid_i & (start_i | active_q);
  assign col_base = sop ? '0 : col_q;
  assign lpa_base = sop ? '0 : lpa_q;
  assign lpb_base = sop ? '0 : lpb_q;
  assign idx      = sop ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q    <= '0;
      lpa_q    <= '0;
      lpb_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (take) begin
      col_q <= col_base ^ col_i;
      lpa_q <= odd_i ? (lpa_base ^ idx)  : lpa_base;
      lpb_q <= odd_i ? (lpb_base ^ ~idx) : lpb_base;
      cnt_q <= idx + 1'b1;
      if (idx == LAST_IDX) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else begin
        active_q <= 1'b1;
        done_q   <= 1'b0;
      end
    end
  end

  assign col_o  = col_q;
  assign lpa_o  = lpa_q;
  assign lpb_o  = lpb_q;
  assign done_o = done_q;

  AST_START_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop |=> (cnt_q == IDX_W'(1)) && active_q && !done_q); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(col_q) && $stable(lpa_q) && $stable(lpb_q) && $stable(cnt_q)); // R10

  AST_IGNORE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !sop |=> done_q && $stable(col_q) && $stable(lpa_q) && $stable(lpb_q)); // R9

  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(cnt_q) == LAST_IDX && $past(take)); // R8
endmodule

// File: rtl/hecc_pack.sv
module hecc_pack
  import nand_hecc_pkg::*;
#(
  parameter bit ALT_ORDER = 1'b0
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [IDX_W-1:0] lpa_i,
  input  logic [IDX_W-1:0] lpb_i,
  output logic [7:0]       ecc0_o,
  output logic [7:0]       ecc1_o,
  output logic [7:0]       ecc2_o
);
  localparam int unsigned HALF = IDX_W / 2;

  logic [7:0] w_hi, w_lo;

  for (genvar t = 0; t < HALF; t++) begin : g_ilv
    assign w_hi[7-2*t] = lpa_i[IDX_W-1-t];
    assign w_hi[6-2*t] = lpb_i[IDX_W-1-t];
    assign w_lo[7-2*t] = lpa_i[HALF-1-t];
    assign w_lo[6-2*t] = lpb_i[HALF-1-t];
  end

  if (ALT_ORDER) begin : g_alt
    assign ecc0_o = ~w_lo;
    assign ecc1_o = ~w_hi;
  end else begin : g_std
    assign ecc0_o = ~w_hi;
    assign ecc1_o = ~w_lo;
  end

  assign ecc2_o = {~col_i, 2'b11};
endmodule

// File: rtl/nand_hecc_gen.sv
module nand_hecc_gen
  import nand_hecc_pkg::*;
#(
  parameter bit ALT_ORDER = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       done_o,
  output logic [7:0] ecc0_o,
  output logic [7:0] ecc1_o,
  output logic [7:0] ecc2_o
);
  logic [COL_W-1:0] byte_col, col_acc;
  logic             byte_odd;
  logic [IDX_W-1:0] lpa, lpb;

  hecc_byte_par u_par (
    .d_i   (data_i),
    .col_o (byte_col),
    .odd_o (byte_odd)
  );

  hecc_accum u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_i (valid_i),
    .col_i   (byte_col),
    .odd_i   (byte_odd),
    .col_o   (col_acc),
    .lpa_o   (lpa),
    .lpb_o   (lpb),
    .done_o  (done_o)
  );

  hecc_pack #(.ALT_ORDER(ALT_ORDER)) u_pack (
    .col_i  (col_acc),
    .lpa_i  (lpa),
    .lpb_i  (lpb),
    .ecc0_o (ecc0_o),
    .ecc1_o (ecc1_o),
    .ecc2_o (ecc2_o)
  );

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !(valid_i && start_i) |=>
      $stable(ecc0_o) && $stable(ecc1_o) && $stable(ecc2_o)); // R9
endmodule

// File: tb/nand_hecc_gen_bench.sv
module nand_hecc_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, valid = 1'b0;
  logic [7:0] data = '0;
  logic       done_s, done_a;
  logic [7:0] e0_s, e1_s, e2_s, e0_a, e1_a, e2_a;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nand_hecc_gen #(.ALT_ORDER(1'b0)) u_nand_hecc_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid), .data_i(data),
    .done_o(done_s), .ecc0_o(e0_s), .ecc1_o(e1_s), .ecc2_o(e2_s));

  nand_hecc_gen #(.ALT_ORDER(1'b1)) u_nand_hecc_gen_alt (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid), .data_i(data),
    .done_o(done_a), .ecc0_o(e0_a), .ecc1_o(e1_a), .ecc2_o(e2_a));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural model ----------------
  logic [7:0] m_bytes [256];
  int         m_cnt = 0;
  bit         m_active = 0, m_done = 0;
  logic [7:0] x_hi, x_lo, x_col;

  function automatic logic [23:0] ref_code();
    logic [7:0] a = 0, b = 0, hi, lo;
    logic [5:0] col = 0;
    logic [7:0] masks [6] = '{8'h55, 8'hAA, 8'h33, 8'hCC, 8'h0F, 8'hF0};
    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < 6; k++) col[k] ^= ^(m_bytes[i] & masks[k]);
      if (^m_bytes[i]) begin
        a ^= 8'(i);
        b ^= ~8'(i);
      end
    end
    for (int t = 0; t < 4; t++) begin
      hi[7-2*t] = a[7-t]; hi[6-2*t] = b[7-t];
      lo[7-2*t] = a[3-t]; lo[6-2*t] = b[3-t];
    end
    return {~hi, ~lo, ~col, 2'b11};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_active = 0; m_done = 0;
    end else if (valid) begin
      if (start) begin
        m_cnt = 0; m_active = 1; m_done = 0;
      end
      if (m_active) begin
        m_bytes[m_cnt] = data;
        m_cnt++;
        if (m_cnt == 256) begin
          m_active = 0; m_done = 1;
          {x_hi, x_lo, x_col} = ref_code();
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R8 done", {31'd0, done_s}, {31'd0, m_done});
      chk("R8 done alt", {31'd0, done_a}, {31'd0, m_done});
      if (m_done) begin
        chk("R3 R4 ecc0", {24'd0, e0_s}, {24'd0, x_hi});
        chk("R3 R4 ecc1", {24'd0, e1_s}, {24'd0, x_lo});
        chk("R2 R6 ecc2", {24'd0, e2_s}, {24'd0, x_col});
        chk("R5 alt ecc0", {24'd0, e0_a}, {24'd0, x_lo});
        chk("R5 alt ecc1", {24'd0, e1_a}, {24'd0, x_hi});
      end
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] blk [256];

  task automatic put(input bit st, input logic [7:0] d);
    @(negedge clk);
    start = st; valid = 1'b1; data = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      start = 1'b0; valid = 1'b0; data = $urandom;
    end
  endtask

  task automatic send(input int n, input int gap_pct);
    for (int i = 0; i < n; i++) begin
      put(i == 0, blk[i]);
      if (($urandom % 100) < gap_pct) idle(1 + $urandom % 3);
    end
    idle(2);
  endtask

  task automatic fill_random();
    for (int i = 0; i < 256; i++) blk[i] = $urandom;
  endtask

  initial begin
    logic [7:0] h0, h1, h2;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 reset done", {31'd0, done_s}, 32'd0);
    chk("R1 reset ecc0", {24'd0, e0_s}, 32'hFF);
    chk("R1 reset ecc1", {24'd0, e1_s}, 32'hFF);
    chk("R1 reset ecc2", {24'd0, e2_s}, 32'hFF);
    rst_n = 1'b1;
    idle(2);

    // single 0x01 at index 0: col 0x15, A=00, B=FF
    for (int i = 0; i < 256; i++) blk[i] = 8'h00;
    blk[0] = 8'h01;
    send(256, 0);
    chk("R2 R6 known ecc2", {24'd0, e2_s}, 32'hAB);
    chk("R4 known ecc0", {24'd0, e0_s}, 32'hAA);
    chk("R4 known ecc1", {24'd0, e1_s}, 32'hAA);
    chk("R8 known done", {31'd0, done_s}, 32'd1);

    // random blocks with gaps
    for (int r = 0; r < 3; r++) begin
      fill_random();
      send(256, 20);
    end

    // all 0xFF: even parity everywhere
    for (int i = 0; i < 256; i++) blk[i] = 8'hFF;
    send(256, 0);
    chk("R2 R3 ff ecc0", {24'd0, e0_s}, 32'hFF);
    chk("R2 R3 ff ecc1", {24'd0, e1_s}, 32'hFF);
    chk("R6 ff ecc2", {24'd0, e2_s}, 32'hFF);

    // single-bit flips of one random block
    fill_random();
    for (int f = 0; f < 4; f++) begin
      int pos = $urandom % 256;
      blk[pos] ^= 8'(1 << ($urandom % 8));
      send(256, 5);
    end

    // R9: bytes after done are ignored
    h0 = e0_s; h1 = e1_s; h2 = e2_s;
    for (int i = 0; i < 12; i++) put(1'b0, $urandom);
    idle(1);
    chk("R9 hold ecc0", {24'd0, e0_s}, {24'd0, h0});
    chk("R9 hold ecc1", {24'd0, e1_s}, {24'd0, h1});
    chk("R9 hold ecc2", {24'd0, e2_s}, {24'd0, h2});
    chk("R9 hold done", {31'd0, done_s}, 32'd1);

    // R11: restart mid-block, R7 start clears partial state
    fill_random();
    send(100, 10);
    chk("R11 partial not done", {31'd0, done_s}, 32'd0);
    fill_random();
    send(256, 10);
    chk("R11 restart done", {31'd0, done_s}, 32'd1);

    // R10: long gaps
    fill_random();
    for (int i = 0; i < 256; i++) begin
      put(i == 0, blk[i]);
      idle(i % 4);
    end
    idle(2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule